// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects every interrupt source of a small microcontroller and reduces them to a single request line and one fixed vector address. Three core sources (timer overflow, external pin edge, port change) each have a flag and an enable. These sit together in one control register with a global enable and a peripheral-group enable. The remaining peripheral sources have their flags in two request registers and their enables in two enable registers that share the same bit layout. The peripheral-group enable gates the combined peripheral request before it reaches the global gate.

Each source raises its flag with a one-cycle set pulse. Software reads and writes all registers through a simple synchronous write port and a combinational read port. When the core takes the interrupt it pulses acknowledge, which clears the global enable so that nesting cannot happen. The return-from-interrupt pulse sets the global enable again. Only the return address is saved, and that happens in the core, so no other context lives here. With the default parameters there are 15 sources in all: 3 core sources and 12 implemented peripheral bits.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every flag, every enable, the global enable and the peripheral-group enable are 0, `irq_req` is 0, and every address reads 0.
- R2: A set pulse on a source sets its flag on the next clock edge, whatever its enable is. The flag stays set until software writes 0 to it.
- R3: When a set pulse and a software write of 0 to the same flag happen in the same cycle, the flag ends up 1.
- R4: A core source raises `irq_req` when its flag, its enable and the global enable are all 1.
- R5: A peripheral source raises `irq_req` only when its flag, its enable, the peripheral-group enable and the global enable are all 1.
- R6: While the global enable is 0, `irq_req` is 0.
- R7: `irq_ack` clears the global enable at the next edge. It wins over a simultaneous `irq_ret` and over a simultaneous register write.
- R8: `irq_ret` without `irq_ack` sets the global enable at the next edge.
- R9: The peripheral source inputs are `src_per[7:0]`, which map to request register 1, and `src_per[15:8]`, which map to request register 2. In register 2 only bits 0, 2, 3 and 4 exist; bit 4 is the nonvolatile-memory write-complete flag. Bits that do not exist read 0 in both the flag and the enable register, and cannot be set.
- R10: Register map. Address 0 is control: bit 7 is the global enable, bit 6 is the peripheral-group enable, bits 5:3 are the core enables and bits 2:0 are the core flags, with core source i at flag bit i and enable bit 3+i. Bits 5:3 and 2:0 follow `src_core[2:0]`. Addresses 1 and 2 are request registers 1 and 2, and addresses 3 and 4 are enable registers 1 and 2. Addresses 5 to 7 read 0.
- R11: `irq_vector` always carries the single vector address 0x004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| src_core | input | 3 | Set pulses for the core sources |
| src_per | input | 16 | Set pulses for the peripheral sources |
| irq_ack | input | 1 | Core has taken the interrupt |
| irq_ret | input | 1 | Core returns from the interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 13 | Vector address for the request |

## Verification
A flag, enable or gate bit that holds a wrong value shows up on `irq_req` in the same cycle that its qualifying bits line up. It is also visible on `rdata` as soon as software reads its address. The bench therefore checks the request and a random read address against a model in every cycle. A stuck global or group enable is thus caught at the first acknowledge, return or write that should have changed it. The directed cases target the set-versus-clear collision, the ack priority, and bits that do not exist.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int ADDR_CTRL      = 0;
   localparam int ADDR_FLAG_BASE = 1;

   function automatic int en_base(input int n_banks);
      return ADDR_FLAG_BASE + n_banks;
   endfunction

   function automatic int regs_used(input int n_banks);
      return 1 + 2 * n_banks;
   endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int               W    = 8,
   parameter logic [W-1:0]     IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         flag_we,
   input  logic [W-1:0] flag_wd,
   input  logic         en_we,
   input  logic [W-1:0] en_wd,
   output logic [W-1:0] flag_o,
   output logic [W-1:0] en_o,
   output logic         pend_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_live
         logic f_q;
         logic e_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f_q <= 1'b0;
               e_q <= 1'b0;
            end else begin
               f_q <= (flag_we ? flag_wd[i] : f_q) | set_i[i];
               if (en_we) e_q <= en_wd[i];
            end
         end
         assign flag_o[i] = f_q;
         assign en_o[i]   = e_q;
      end else begin : g_absent
         assign flag_o[i] = 1'b0;
         assign en_o[i]   = 1'b0;
      end
   end

   assign pend_o = |(flag_o & en_o);
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic ge_wd,
   input  logic pge_wd,
   input  logic ack,
   input  logic ret,
   output logic ge,
   output logic pge
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ge  <= 1'b0;
         pge <= 1'b0;
      end else begin
         if (ack)      ge <= 1'b0;
         else if (ret) ge <= 1'b1;
         else if (we)  ge <= ge_wd;
         if (we) pge <= pge_wd;
      end
   end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
   parameter int NPB = 2
) (
   input  logic           ge,
   input  logic           pge,
   input  logic           core_pend,
   input  logic [NPB-1:0] per_pend,
   output logic           req
);
   logic group_req;
   assign group_req = pge & (|per_pend);
   assign req       = ge & (core_pend | group_req);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int                   DW       = 8,
   parameter int                   AW       = 3,
   parameter int                   NCORE    = 3,
   parameter int                   NPB      = 2,
   parameter logic [NPB*DW-1:0]    PER_IMPL = 16'h1DFF,
   parameter int                   VW       = 13,
   parameter logic [VW-1:0]        VECTOR   = 13'h0004
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [AW-1:0]       addr,
   input  logic [DW-1:0]       wdata,
   output logic [DW-1:0]       rdata,
   input  logic [NCORE-1:0]    src_core,
   input  logic [NPB*DW-1:0]   src_per,
   input  logic                irq_ack,
   input  logic                irq_ret,
   output logic                irq_req,
   output logic [VW-1:0]       irq_vector
);
   localparam int BIT_GE   = DW - 1;
   localparam int BIT_PGE  = DW - 2;
   localparam int EN_LO    = NCORE;
   localparam int EN_BASE  = en_base(NPB);

   if (DW < 2 + 2 * NCORE) begin : g_chk_dw
      $error("control register too narrow for core sources");
   end
   if (regs_used(NPB) > (1 << AW)) begin : g_chk_aw
      $error("address space too small for register banks");
   end

   logic                      ge, pge;
   logic                      ctrl_we;
   logic [NCORE-1:0]          core_flag, core_en;
   logic                      core_pend;
   logic [NPB-1:0][DW-1:0]    per_flag, per_en;
   logic [NPB-1:0]            per_pend;

   assign ctrl_we = wr_en && (addr == AW'(ADDR_CTRL));

   irq_gate_ctrl u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ctrl_we),
      .ge_wd  (wdata[BIT_GE]),
      .pge_wd (wdata[BIT_PGE]),
      .ack    (irq_ack),
      .ret    (irq_ret),
      .ge     (ge),
      .pge    (pge)
   );

   irq_src_bank #(.W(NCORE), .IMPL({NCORE{1'b1}})) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (src_core),
      .flag_we (ctrl_we),
      .flag_wd (wdata[NCORE-1:0]),
      .en_we   (ctrl_we),
      .en_wd   (wdata[EN_LO +: NCORE]),
      .flag_o  (core_flag),
      .en_o    (core_en),
      .pend_o  (core_pend)
   );

   for (genvar g = 0; g < NPB; g++) begin : g_bank
      logic f_we, e_we;
      assign f_we = wr_en && (addr == AW'(ADDR_FLAG_BASE + g));
      assign e_we = wr_en && (addr == AW'(EN_BASE + g));
      irq_src_bank #(.W(DW), .IMPL(PER_IMPL[g*DW +: DW])) u_per (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (src_per[g*DW +: DW]),
         .flag_we (f_we),
         .flag_wd (wdata),
         .en_we   (e_we),
         .en_wd   (wdata),
         .flag_o  (per_flag[g]),
         .en_o    (per_en[g]),
         .pend_o  (per_pend[g])
      );
   end

   irq_combine #(.NPB(NPB)) u_comb (
      .ge        (ge),
      .pge       (pge),
      .core_pend (core_pend),
      .per_pend  (per_pend),
      .req       (irq_req)
   );

   always_comb begin
      rdata = '0;
      if (addr == AW'(ADDR_CTRL)) begin
         rdata[BIT_GE]            = ge;
         rdata[BIT_PGE]           = pge;
         rdata[EN_LO +: NCORE]    = core_en;
         rdata[NCORE-1:0]         = core_flag;
      end
      for (int g = 0; g < NPB; g++) begin
         if (addr == AW'(ADDR_FLAG_BASE + g)) rdata = per_flag[g];
         if (addr == AW'(EN_BASE + g))        rdata = per_en[g];
      end
   end

   assign irq_vector = VECTOR;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int                DW       = 8,
   parameter int                AW       = 3,
   parameter int                NCORE    = 3,
   parameter int                NPB      = 2,
   parameter logic [NPB*DW-1:0] PER_IMPL = 16'h1DFF
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [AW-1:0]       addr,
   input logic [DW-1:0]       wdata,
   input logic [NCORE-1:0]    src_core,
   input logic [NPB*DW-1:0]   src_per,
   input logic                irq_ack,
   input logic                irq_ret,
   input logic                irq_req,
   input logic                ge,
   input logic                pge,
   input logic [NCORE-1:0]    core_flag,
   input logic [NCORE-1:0]    core_en,
   input logic [NPB*DW-1:0]   per_flag
);
   p_req_needs_ge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ge);

   p_group_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !pge) |-> (|(core_flag & core_en)));

   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !ge);

   p_ret_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_ack) |=> ge);

   p_core_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      src_core[0] |=> core_flag[0]);

   p_set_beats_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_per[0] && wr_en && addr == AW'(1) && !wdata[0]) |=> per_flag[0]);

   p_absent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (per_flag & ~PER_IMPL) == '0);
endmodule

bind irq_aggregator irq_aggregator_chk #(
   .DW(DW), .AW(AW), .NCORE(NCORE), .NPB(NPB), .PER_IMPL(PER_IMPL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .src_core  (src_core),
   .src_per   (src_per),
   .irq_ack   (irq_ack),
   .irq_ret   (irq_ret),
   .irq_req   (irq_req),
   .ge        (ge),
   .pge       (pge),
   .core_flag (core_flag),
   .core_en   (core_en),
   .per_flag  (per_flag)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [2:0]  src_core = '0;
   logic [15:0] src_per = '0;
   logic        irq_ack = 1'b0;
   logic        irq_ret = 1'b0;
   logic        irq_req;
   logic [12:0] irq_vector;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   localparam logic [7:0] IMPL1 = 8'hFF;
   localparam logic [7:0] IMPL2 = 8'h1D;

   logic       m_ge = 0, m_pge = 0;
   logic [2:0] m_cf = 0, m_ce = 0;
   logic [7:0] m_f1 = 0, m_f2 = 0, m_e1 = 0, m_e2 = 0;

   always #2.5 clk = ~clk;

   irq_aggregator u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .src_core(src_core), .src_per(src_per),
      .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
      .irq_vector(irq_vector)
   );

   function automatic logic exp_req();
      return m_ge && ((|(m_cf & m_ce)) ||
                      (m_pge && (|((m_f1 & m_e1) | (m_f2 & m_e2)))));
   endfunction

   function automatic logic [7:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return {m_ge, m_pge, m_ce, m_cf};
         3'd1: return m_f1;
         3'd2: return m_f2;
         3'd3: return m_e1;
         3'd4: return m_e2;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_update();
      logic wc;
      wc = wr_en && addr == 3'd0;
      if (irq_ack)      m_ge = 1'b0;
      else if (irq_ret) m_ge = 1'b1;
      else if (wc)      m_ge = wdata[7];
      if (wc) begin
         m_pge = wdata[6];
         m_ce  = wdata[5:3];
      end
      m_cf = (wc ? wdata[2:0] : m_cf) | src_core;
      m_f1 = ((wr_en && addr == 3'd1 ? wdata : m_f1) | src_per[7:0])  & IMPL1;
      m_f2 = ((wr_en && addr == 3'd2 ? wdata : m_f2) | src_per[15:8]) & IMPL2;
      if (wr_en && addr == 3'd3) m_e1 = wdata & IMPL1;
      if (wr_en && addr == 3'd4) m_e2 = wdata & IMPL2;
   endtask

   // One cycle: drive, compare against model, clock, update model.
   task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d,
                      input logic [2:0] sc, input logic [15:0] sp,
                      input logic ak, input logic rt, input string tag);
      @(negedge clk);
      wr_en = we; addr = a; wdata = d; src_core = sc; src_per = sp;
      irq_ack = ak; irq_ret = rt;
      #1;
      check({tag, " req"}, {15'd0, irq_req}, {15'd0, exp_req()});
      check({tag, " rdata"}, {8'd0, rdata}, {8'd0, exp_rd(a)});
      if (irq_req) check("R11 vector", {3'd0, irq_vector}, 16'h0004);
      @(posedge clk);
      #0.5;
      model_update();
   endtask

   // Idle read with explicit expected values.
   task automatic peek(input logic [2:0] a, input logic ereq, input logic [7:0] erd,
                       input string tag);
      @(negedge clk);
      wr_en = 0; addr = a; wdata = 0; src_core = 0; src_per = 0;
      irq_ack = 0; irq_ret = 0;
      #1;
      check({tag, " req"}, {15'd0, irq_req}, {15'd0, ereq});
      check({tag, " rdata"}, {8'd0, rdata}, {8'd0, erd});
      @(posedge clk);
      #0.5;
      model_update();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      for (int a = 0; a < 8; a++) begin
         addr = 3'(a);
         #0.2;
         check("R1 reset rdata", {8'd0, rdata}, 16'h0000);
      end
      check("R1 reset req", {15'd0, irq_req}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: flag sets while disabled, no request
      cyc(0, 3'd0, 8'h00, 3'b000, 16'h0001, 0, 0, "R2");
      peek(3'd1, 1'b0, 8'h01, "R2 flag set");
      // R5: global on, group off -> no request
      cyc(1, 3'd0, 8'h80, 3'b000, 16'h0000, 0, 0, "R5");
      cyc(1, 3'd3, 8'h01, 3'b000, 16'h0000, 0, 0, "R5");
      peek(3'd0, 1'b0, 8'h80, "R5 group off");
      cyc(1, 3'd0, 8'hC0, 3'b000, 16'h0000, 0, 0, "R5");
      peek(3'd0, 1'b1, 8'hC0, "R5 group on");
      // R7 / R8
      cyc(0, 3'd0, 8'h00, 3'b000, 16'h0000, 1, 0, "R7");
      peek(3'd0, 1'b0, 8'h40, "R7 ack clears");
      cyc(0, 3'd0, 8'h00, 3'b000, 16'h0000, 0, 1, "R8");
      peek(3'd0, 1'b1, 8'hC0, "R8 ret sets");
      // R3: set beats clear
      cyc(1, 3'd1, 8'h00, 3'b000, 16'h0001, 0, 0, "R3");
      peek(3'd1, 1'b1, 8'h01, "R3 set wins");
      cyc(1, 3'd1, 8'h00, 3'b000, 16'h0000, 0, 0, "R2");
      peek(3'd1, 1'b0, 8'h00, "R2 sw clear");
      // R9: absent bits
      cyc(1, 3'd2, 8'hFF, 3'b000, 16'h0000, 0, 0, "R9");
      cyc(1, 3'd4, 8'hFF, 3'b000, 16'hFF00, 0, 0, "R9");
      peek(3'd2, 1'b1, 8'h1D, "R9 flag2");
      peek(3'd4, 1'b1, 8'h1D, "R9 en2");
      // R4: core source, group disabled
      cyc(1, 3'd0, 8'h88, 3'b000, 16'h0000, 0, 0, "R4");
      peek(3'd0, 1'b0, 8'h88, "R4 no flag");
      cyc(0, 3'd0, 8'h00, 3'b001, 16'h0000, 0, 0, "R4");
      peek(3'd0, 1'b1, 8'h89, "R4 core req");
      // R6
      cyc(1, 3'd0, 8'h09, 3'b000, 16'h0000, 0, 0, "R6");
      peek(3'd0, 1'b0, 8'h09, "R6 global off");
      // R10 unused addresses
      peek(3'd5, 1'b0, 8'h00, "R10 addr5");
      peek(3'd7, 1'b0, 8'h00, "R10 addr7");
      // R7 priority over ret and write
      cyc(1, 3'd0, 8'h89, 3'b000, 16'h0000, 1, 1, "R7");
      peek(3'd0, 1'b0, 8'h09, "R7 ack priority");

      // Random phase
      for (int i = 0; i < 4000; i++) begin
         logic we, ak, rt;
         logic [2:0] a, sc;
         logic [15:0] sp;
         logic [7:0] d;
         we = ($urandom % 5) == 0;
         a  = 3'($urandom % 8);
         d  = 8'($urandom);
         sc = 3'($urandom) & 3'($urandom) & 3'($urandom);
         sp = 16'($urandom) & 16'($urandom) & 16'($urandom);
         ak = ($urandom % 20) == 0;
         rt = ($urandom % 20) == 0;
         cyc(we, a, d, sc, sp, ak, rt, (i % 2) ? "R4" : "R10");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule